// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer Core

This block is a 32-bit processor core in which every instruction passes through a short series of one-clock steps. All classes share one datapath. The core holds a program counter, an instruction latch, two operand latches, a result latch, a read-data latch and a 32-entry register file. It talks to one combined instruction and data memory through a single port. Reads return data in the same cycle that the read strobe is high.

Each instruction starts with a fetch step and a decode step. During decode the core always forms a tentative branch target, whatever the opcode turns out to be. After decode, control moves through steps that depend on the instruction class. The states are `ST_FETCH`, `ST_DECODE`, `ST_EXEC_R`, `ST_WB_R`, `ST_ADDR`, `ST_MEM_RD`, `ST_MEM_WR`, `ST_WB_LD`, `ST_BRANCH` and `ST_JUMP`. The transitions are:

- FETCH→DECODE.
- DECODE→EXEC_R, ADDR, BRANCH, JUMP or back to FETCH, chosen by the opcode.
- EXEC_R→WB_R→FETCH.
- ADDR→MEM_RD when the instruction is a load, and ADDR→MEM_WR when it is a store.
- MEM_RD→WB_LD→FETCH.
- MEM_WR, BRANCH and JUMP each return to FETCH.

Instruction fields: the opcode sits in bits 31..26, the first source register in 25..21, the second source or load destination in 20..16, the R-type destination in 15..11, a signed 16-bit immediate in 15..0, the function code in 5..0 and the jump target in 25..0.

Top module: `mc_core`

## Requirements
- R1: While reset is low and in the first cycle after it, the core is in the fetch step with the program counter at 0: mem_rd is 1, mem_wr is 0 and mem_addr is 0.
- R2: A fetch step drives mem_rd with mem_addr equal to the program counter. It loads the instruction latch from mem_rdata and adds 4 to the program counter. The next step is always decode.
- R3: Decode latches operands from the registers named by bits 25..21 and 20..16. It also stores, as a tentative branch target, the incremented program counter plus the sign-extended immediate shifted left by 2.
- R4: Opcode 0 selects an R-type operation through the function code: 32 is add, 34 is subtract, 36 is AND, 37 is OR and 42 is signed set-less-than, which gives 1 or 0. The result is written to the register named by bits 15..11. The instruction takes 4 cycles.
- R5: Opcode 35 is a word load. It reads memory at operand A plus the sign-extended immediate in its fourth cycle and writes that word to the register named by bits 20..16. The instruction takes 5 cycles.
- R6: Opcode 43 is a word store. It drives mem_wr with mem_wdata equal to operand B at address A plus the sign-extended immediate in its fourth and last cycle. No other instruction ever drives mem_wr.
- R7: Opcode 4 is branch-if-equal and takes 3 cycles. When the operands are equal, the next fetch is at the tentative target from R3, with a positive or negative offset. When they differ, execution continues at the next word.
- R8: Opcode 2 is a jump and takes 3 cycles. The new program counter is the top 4 bits of the incremented counter, followed by bits 25..0 of the instruction, followed by two zero bits.
- R9: Any other opcode takes 2 cycles. It changes no register and no memory word, and execution continues at the next word.
- R10: Register 0 always reads as 0. A write that names it has no effect.
- R11: mem_rd and mem_wr are never high in the same cycle. mem_rd is high only in fetch and in the load read step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address: the program counter, or the result latch during data steps |
| mem_wdata | output | 32 | Store data (operand B) |
| mem_rdata | input | 32 | Read data, valid in the same cycle as mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The assertions check the following on every cycle:

- The strobes never overlap.
- Decode always follows fetch, and fetch always adds 4 to the program counter.
- A load read step always leads to its write-back.
- A source of register 0 always latches zero.
- A branch whose operands differ leaves the program counter alone.
- A jump keeps the top four counter bits.
- Writes occur only for the store opcode.

Only the directed programs can show that results are correct:

- the arithmetic values and signed comparison;
- loop results produced by backward branches;
- negative load and store offsets;
- the exact cycle of each fetch, which gives the per-class step counts.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC_R,
        ST_WB_R,
        ST_ADDR,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_WB_LD,
        ST_BRANCH,
        ST_JUMP
    } step_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_ZERO
    } alu_op_e;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    // operand-Y source for the shared ALU
    localparam logic [1:0] YSEL_B     = 2'd0;
    localparam logic [1:0] YSEL_IMM   = 2'd1;
    localparam logic [1:0] YSEL_IMMX4 = 2'd2;

    typedef struct packed {
        logic       ir_we;
        logic       pc_inc;
        logic       ab_we;
        logic       out_we;
        logic       alu_x_pc;
        logic [1:0] alu_y_sel;
        logic       alu_use_funct;
        logic       mdr_we;
        logic       rf_we;
        logic       rf_src_mdr;
        logic       pc_take_out;
        logic       pc_jump;
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_addr_out;
    } ctrl_t;

    function automatic alu_op_e funct_to_alu(input logic [5:0] fn);
        alu_op_e op;
        case (fn)
            FN_ADD:  op = ALU_ADD;
            FN_SUB:  op = ALU_SUB;
            FN_AND:  op = ALU_AND;
            FN_OR:   op = ALU_OR;
            FN_SLT:  op = ALU_SLT;
            default: op = ALU_ZERO;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   res
);

    always_comb begin
        unique case (op)
            ALU_ADD:  res = x + y;
            ALU_SUB:  res = x - y;
            ALU_AND:  res = x & y;
            ALU_OR:   res = x | y;
            ALU_SLT:  res = ($signed(x) < $signed(y)) ? W'(1) : '0;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_sel_a,
    input  logic [AW-1:0] rd_sel_b,
    output logic [W-1:0]  rd_val_a,
    output logic [W-1:0]  rd_val_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_val
);

    logic [NREG-1:0][W-1:0] entries;

    // entry 0 is hard-wired to zero; it has no storage
    assign entries[0] = '0;

    generate
        for (genvar g = 1; g < NREG; g++) begin : g_entry
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_sel == AW'(g))) begin
                    q <= wr_val;
                end
            end
            assign entries[g] = q;
        end
    endgenerate

    assign rd_val_a = entries[rd_sel_a];
    assign rd_val_b = entries[rd_sel_b];

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic       a_eq_b,
    output step_e      state,
    output ctrl_t      ctrl
);

    step_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_RTYPE:         state_nx = ST_EXEC_R;
                    OP_LOAD, OP_STORE: state_nx = ST_ADDR;
                    OP_BEQ:           state_nx = ST_BRANCH;
                    OP_JUMP:          state_nx = ST_JUMP;
                    default:          state_nx = ST_FETCH;
                endcase
            end
            ST_EXEC_R: state_nx = ST_WB_R;
            ST_ADDR:   state_nx = (opcode == OP_LOAD) ? ST_MEM_RD : ST_MEM_WR;
            ST_MEM_RD: state_nx = ST_WB_LD;
            ST_WB_R, ST_WB_LD, ST_MEM_WR, ST_BRANCH, ST_JUMP: state_nx = ST_FETCH;
            default:   state_nx = ST_FETCH;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd = 1'b1;
                ctrl.ir_we  = 1'b1;
                ctrl.pc_inc = 1'b1;
            end
            ST_DECODE: begin
                ctrl.ab_we     = 1'b1;
                ctrl.out_we    = 1'b1;
                ctrl.alu_x_pc  = 1'b1;
                ctrl.alu_y_sel = YSEL_IMMX4;
            end
            ST_EXEC_R: begin
                ctrl.out_we        = 1'b1;
                ctrl.alu_y_sel     = YSEL_B;
                ctrl.alu_use_funct = 1'b1;
            end
            ST_WB_R: ctrl.rf_we = 1'b1;
            ST_ADDR: begin
                ctrl.out_we    = 1'b1;
                ctrl.alu_y_sel = YSEL_IMM;
            end
            ST_MEM_RD: begin
                ctrl.mem_rd       = 1'b1;
                ctrl.mem_addr_out = 1'b1;
                ctrl.mdr_we       = 1'b1;
            end
            ST_MEM_WR: begin
                ctrl.mem_wr       = 1'b1;
                ctrl.mem_addr_out = 1'b1;
            end
            ST_WB_LD: begin
                ctrl.rf_we      = 1'b1;
                ctrl.rf_src_mdr = 1'b1;
            end
            ST_BRANCH: ctrl.pc_take_out = a_eq_b;
            ST_JUMP:   ctrl.pc_jump     = 1'b1;
            default:   ctrl = '0;
        endcase
    end

    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |-> ($past(state) == ST_FETCH)); // R2
    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM_RD) |=> (state == ST_WB_LD)); // R5
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.mem_rd && ctrl.mem_wr)); // R11

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int W   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_rd,
    output logic         mem_wr
);

    step_e        state;
    ctrl_t        ctrl;
    logic [W-1:0] pc, ir, a_q, b_q, out_q, mdr;
    logic [W-1:0] rf_a, rf_b, alu_x, alu_y, alu_res;
    logic [W-1:0] imm_sx, imm_x4, pc_plus4;
    alu_op_e      alu_op;

    // instruction fields
    logic [5:0]    opcode, funct;
    logic [AW-1:0] rs_f, rt_f, rd_f;
    assign opcode = ir[31:26];
    assign funct  = ir[5:0];
    assign rs_f   = ir[21 +: AW];
    assign rt_f   = ir[16 +: AW];
    assign rd_f   = ir[11 +: AW];
    assign imm_sx = {{(W-16){ir[15]}}, ir[15:0]};
    assign imm_x4 = {imm_sx[W-3:0], 2'b00};
    assign pc_plus4 = pc + W'(4);

    mc_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .a_eq_b (a_q == b_q),
        .state  (state),
        .ctrl   (ctrl)
    );

    mc_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_a (rs_f),
        .rd_sel_b (rt_f),
        .rd_val_a (rf_a),
        .rd_val_b (rf_b),
        .wr_en    (ctrl.rf_we),
        .wr_sel   (ctrl.rf_src_mdr ? rt_f : rd_f),
        .wr_val   (ctrl.rf_src_mdr ? mdr : out_q)
    );

    always_comb begin
        alu_x = ctrl.alu_x_pc ? pc : a_q;
        case (ctrl.alu_y_sel)
            YSEL_B:     alu_y = b_q;
            YSEL_IMM:   alu_y = imm_sx;
            YSEL_IMMX4: alu_y = imm_x4;
            default:    alu_y = '0;
        endcase
        alu_op = ctrl.alu_use_funct ? funct_to_alu(funct) : ALU_ADD;
    end

    mc_alu #(.W(W)) u_alu (
        .op  (alu_op),
        .x   (alu_x),
        .y   (alu_y),
        .res (alu_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            a_q   <= '0;
            b_q   <= '0;
            out_q <= '0;
            mdr   <= '0;
        end else begin
            if (ctrl.ir_we)  ir  <= mem_rdata;
            if (ctrl.mdr_we) mdr <= mem_rdata;
            if (ctrl.ab_we) begin
                a_q <= rf_a;
                b_q <= rf_b;
            end
            if (ctrl.out_we) out_q <= alu_res;
            if (ctrl.pc_inc)
                pc <= pc_plus4;
            else if (ctrl.pc_take_out)
                pc <= out_q;
            else if (ctrl.pc_jump)
                pc <= {pc[W-1:W-4], ir[25:0], 2'b00};
        end
    end

    assign mem_addr  = ctrl.mem_addr_out ? out_q : pc;
    assign mem_wdata = b_q;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == $past(pc) + W'(4))); // R2
    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && rs_f == '0) |=> (a_q == '0)); // R10
    AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRANCH && a_q != b_q) |=> $stable(pc)); // R7
    AST_JUMP_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JUMP) |=> (pc[W-1:W-4] == $past(pc[W-1:W-4]))); // R8
    AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (opcode == OP_STORE)); // R6

endmodule

// File: tb/test_mc_core.sv
module test_mc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;

    logic [31:0] mem [256];
    int n_chk = 0;
    int n_fail = 0;

    int          cyc;
    int          rd_n, wr_n, clash;
    int          rd_cyc [64];
    logic [31:0] rd_adr [64];
    int          wr_cyc [64];
    logic [31:0] wr_adr [64];
    logic [31:0] wr_dat [64];

    always #10 clk = ~clk;

    mc_core i_mc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (rst_n && mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd && rd_n < 64) begin
                rd_cyc[rd_n] = cyc;
                rd_adr[rd_n] = mem_addr;
                rd_n++;
            end
            if (mem_wr && wr_n < 64) begin
                wr_cyc[wr_n] = cyc;
                wr_adr[wr_n] = mem_addr;
                wr_dat[wr_n] = mem_wdata;
                wr_n++;
            end
            if (mem_rd && mem_wr) clash++;
            cyc++;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'd2, tgt[25:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic start_core();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        cyc = 0; rd_n = 0; wr_n = 0; clash = 0;
        #2 rst_n = 1'b1;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // R1, R2, R9: reset state and unknown opcodes
    task automatic t_reset_and_noop();
        clear_mem();
        for (int i = 0; i < 8; i++) mem[i] = enc_i(63, 0, 0, 0);
        start_core();
        @(negedge clk); #1;
        chk("R1 mem_rd after reset", {31'd0, mem_rd}, 32'd1);
        chk("R1 mem_wr after reset", {31'd0, mem_wr}, 32'd0);
        chk("R1 mem_addr after reset", mem_addr, 32'd0);
        run(6);
        for (int k = 0; k < 3; k++) begin
            chk("R2 fetch address", rd_adr[k], 32'(4 * k));
            chk("R9 two-cycle step", 32'(rd_cyc[k]), 32'(2 * k));
        end
        chk("R9 no writes", 32'(wr_n), 32'd0);
    endtask

    // R4, R10: arithmetic results observed through stores
    task automatic t_rtype();
        clear_mem();
        mem[64] = 32'd7;
        mem[65] = 32'hFFFF_FFFD;
        mem[134] = 32'hDEAD_BEEF;
        mem[0] = enc_i(35, 0, 1, 'h100);
        mem[1] = enc_i(35, 0, 2, 'h104);
        mem[2] = enc_r(1, 2, 3, 32);
        mem[3] = enc_r(1, 2, 4, 34);
        mem[4] = enc_r(1, 2, 5, 36);
        mem[5] = enc_r(1, 2, 6, 37);
        mem[6] = enc_r(2, 1, 7, 42);
        mem[7] = enc_r(1, 2, 8, 42);
        mem[8] = enc_r(1, 1, 0, 32);
        for (int k = 0; k < 7; k++)
            mem[9 + k] = enc_i(43, 0, (k < 6) ? 3 + k : 0, 'h200 + 4 * k);
        mem[16] = enc_j(16);
        start_core();
        run(150);
        chk("R4 add", mem[128], 32'd4);
        chk("R4 subtract", mem[129], 32'd10);
        chk("R4 and", mem[130], 32'd5);
        chk("R4 or", mem[131], 32'hFFFF_FFFF);
        chk("R4 slt true", mem[132], 32'd1);
        chk("R4 slt false signed", mem[133], 32'd0);
        chk("R10 register zero ignores write", mem[134], 32'd0);
    endtask

    // R2, R4..R9, R11: per-class step counts via the bus log
    task automatic t_timing();
        int exp_c [10] = '{0, 4, 7, 9, 13, 16, 19, 21, 24, 27};
        logic [31:0] exp_a [10] = '{32'h0, 32'h4, 32'h100, 32'h8, 32'hC,
                                    32'h14, 32'h18, 32'h1C, 32'h40, 32'h40};
        clear_mem();
        mem[64] = 32'd5;
        mem[0] = enc_r(0, 0, 0, 32);
        mem[1] = enc_i(35, 0, 1, 'h100);
        mem[2] = enc_i(43, 0, 1, 'h104);
        mem[3] = enc_i(4, 0, 0, 1);
        mem[4] = enc_i(43, 0, 1, 'h108);
        mem[5] = enc_i(4, 0, 1, 5);
        mem[6] = enc_i(63, 0, 0, 0);
        mem[7] = enc_j(16);
        mem[16] = enc_j(16);
        start_core();
        run(30);
        chk("R5 R7 R8 read count", 32'(rd_n), 32'd10);
        for (int k = 0; k < 10; k++) begin
            chk("R2 R4 R5 R6 R7 R9 read cycle", 32'(rd_cyc[k]), 32'(exp_c[k]));
            chk("R3 R5 R7 R8 read address", rd_adr[k], exp_a[k]);
        end
        chk("R6 R7 single write", 32'(wr_n), 32'd1);
        chk("R6 write cycle", 32'(wr_cyc[0]), 32'd12);
        chk("R6 write address", wr_adr[0], 32'h104);
        chk("R6 write data", wr_dat[0], 32'd5);
        chk("R11 no strobe overlap", 32'(clash), 32'd0);
    endtask

    // R7: loop with a backward branch
    task automatic t_loop();
        clear_mem();
        mem[64] = 32'd3;
        mem[65] = 32'hFFFF_FFFF;
        mem[66] = 32'd10;
        mem[0] = enc_i(35, 0, 1, 'h100);
        mem[1] = enc_i(35, 0, 2, 'h104);
        mem[2] = enc_i(35, 0, 4, 'h108);
        mem[3] = enc_r(3, 4, 3, 32);
        mem[4] = enc_r(1, 2, 1, 32);
        mem[5] = enc_i(4, 1, 0, 1);
        mem[6] = enc_i(4, 0, 0, -4);
        mem[7] = enc_i(43, 0, 3, 'h200);
        mem[8] = enc_j(8);
        start_core();
        run(150);
        chk("R7 backward branch loop sum", mem[128], 32'd30);
    endtask

    // R5, R6: negative and positive offsets
    task automatic t_offsets();
        clear_mem();
        mem[64] = 32'h120;
        mem[71] = 32'hCAFE_0001;
        mem[69] = 32'h5A5A_5A5A;
        mem[0] = enc_i(35, 0, 6, 'h100);
        mem[1] = enc_i(35, 6, 5, -4);
        mem[2] = enc_i(43, 6, 5, 'hE0);
        mem[3] = enc_i(43, 6, 5, -16);
        mem[4] = enc_j(4);
        start_core();
        run(80);
        chk("R5 R6 positive offset store", mem[128], 32'hCAFE_0001);
        chk("R5 R6 negative offset store", mem[68], 32'hCAFE_0001);
        chk("R6 neighbour untouched", mem[69], 32'h5A5A_5A5A);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_and_noop();
        t_rtype();
        t_timing();
        t_loop();
        t_offsets();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule